// File: doc/BRIEF.md
# PLL Run Control and Lock Timing Unit

This block sits between a register bus and an analog PLL. Software starts or stops the PLL through one control register whose bit 0 is a stop bit (1 means stopped). Writes are honoured only while a write-unlock input is high. A second, read-only status location reports whether the PLL output may be used. It also reports whether software has ever broken the start and stop ordering rules.

The stable indication is modelled by timing rather than measured. It rises a fixed number of cycles after the PLL is started, and it falls a fixed, separately parameterised number of cycles after the PLL is stopped. One down-counter times both intervals. The unit refuses a write that would stop the PLL while it is still settling or while it drives the system clock. It also refuses a restart while the oscillator is still winding down. A refused write leaves the control bit untouched and sets a sticky error bit.

Top module: `pll_run_ctrl`

## Requirements
- R1: The control register sits at offset 0. Bit 0 is the stop bit, where 1 means stopped and 0 means running. `pll_run_en` is always the inverse of that bit. Register updates become visible on the clock edge that samples the write strobe.
- R2: After reset, offset 0 reads 0x01, offset 1 reads 0x00, `pll_run_en` is 0 and `pll_stable` is 0.
- R3: At offset 0, bits 7..1 always read 0 whatever was written. At offset 1, bits 7..2 read 0. Offsets 2 and 3 read 0x00.
- R4: A write strobe while `wr_unlock` is 0 changes neither the control bit nor the error bit.
- R5: An accepted start happens when 0 is written to bit 0 while stopped with `pll_stable` at 0. `pll_run_en` rises on the edge that samples the strobe, and `pll_stable` rises exactly SETTLE_CYC cycles later.
- R6: An accepted stop happens when 1 is written while running, with `pll_stable` at 1 and `pll_is_sysclk` at 0. `pll_run_en` falls on the sampling edge, and `pll_stable` falls exactly STOP_CYC cycles later.
- R7: A stop write while `pll_is_sysclk` is 1 is dropped, so the PLL keeps running, and the error bit is set.
- R8: A stop write while settling (`pll_run_en` 1, `pll_stable` 0) is dropped and sets the error bit.
- R9: A start write while winding down (`pll_run_en` 0, `pll_stable` 1) is dropped and sets the error bit.
- R10: A write of the value bit 0 already holds has no effect and sets no error. Writes to offset 1 have no effect.
- R11: Offset 1 returns `pll_stable` in bit 0 and the error bit in bit 1. Once set, the error bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| wr_unlock | input | 1 | Write protection gate, 1 allows writes |
| pll_is_sysclk | input | 1 | PLL currently drives the system clock |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pll_run_en | output | 1 | Run enable to the PLL |
| pll_stable | output | 1 | PLL output considered settled |

## Verification
The bench builds the unit with SETTLE_CYC = 7 and STOP_CYC = 3. With these values the two intervals differ, so a swap of the two reload values shows up. They are also short enough that a write can be landed deliberately in the middle of settling or winding down to reach the refusal paths. They let thousands of random writes cycle the PLL through every phase many times, with a behavioural model compared on every clock.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_RAMP  = 2'd1,
        PH_LOCK  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;
endpackage

// File: rtl/pllc_gate.sv
module pllc_gate
    import pllc_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              bus_we,
    input  logic              wr_unlock,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              want_stop,
    input  logic              pll_is_sysclk,
    input  phase_e            phase,
    output logic              go_run,
    output logic              go_stop,
    output logic              bad_req
);
    logic hit;

    // Decide whether a control write is accepted, refused or a no-op.
    always_comb begin
        hit     = bus_we && wr_unlock && (bus_addr == '0);
        go_run  = 1'b0;
        go_stop = 1'b0;
        bad_req = 1'b0;
        if (hit) begin
            if (!want_stop) begin
                if (phase == PH_OFF)        go_run  = 1'b1;
                else if (phase == PH_DRAIN) bad_req = 1'b1;
            end else begin
                if (phase == PH_LOCK && !pll_is_sysclk)        go_stop = 1'b1;
                else if (phase == PH_RAMP || phase == PH_LOCK) bad_req = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pllc_seq.sv
module pllc_seq
    import pllc_pkg::*;
#(
    parameter int SETTLE_CYC = 200,
    parameter int STOP_CYC   = 48,
    parameter int CNT_W      = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_run,
    input  logic   go_stop,
    output phase_e phase,
    output logic   stable
);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] STOP_LOAD   = CNT_W'(STOP_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_OFF: if (go_run) begin
                s_d.ph  = PH_RAMP;
                s_d.cnt = SETTLE_LOAD;
            end
            PH_RAMP: if (s_q.cnt == '0) s_d.ph = PH_LOCK;
                     else s_d.cnt = s_q.cnt - 1'b1;
            PH_LOCK: if (go_stop) begin
                s_d.ph  = PH_DRAIN;
                s_d.cnt = STOP_LOAD;
            end
            PH_DRAIN: if (s_q.cnt == '0) s_d.ph = PH_OFF;
                      else s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.ph = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_OFF;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase  = s_q.ph;
    assign stable = (s_q.ph == PH_LOCK) || (s_q.ph == PH_DRAIN);

    // A settling PLL can only finish settling; no stop can cut it short.
    assert_ramp_no_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RAMP) |=> (s_q.ph == PH_RAMP || s_q.ph == PH_LOCK));

    // A winding-down PLL can only reach the stopped phase.
    assert_drain_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DRAIN) |=> (s_q.ph == PH_DRAIN || s_q.ph == PH_OFF));
endmodule

// File: rtl/pllc_regs.sv
module pllc_regs
    import pllc_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_run,
    input  logic              go_stop,
    input  logic              bad_req,
    input  logic              stable_in,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              stop_bit,
    output logic              err_flag
);
    typedef struct packed {
        logic stop;
        logic err;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (go_run)  r_d.stop = 1'b0;
        if (go_stop) r_d.stop = 1'b1;
        if (bad_req) r_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stop <= 1'b1;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0)) begin
            bus_rdata[0] = r_q.stop;
        end else if (bus_addr == ADDR_W'(1)) begin
            bus_rdata[0] = stable_in;
            bus_rdata[1] = r_q.err;
        end
    end

    assign stop_bit = r_q.stop;
    assign err_flag = r_q.err;

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W-1:2] == '0);
endmodule

// File: rtl/pll_run_ctrl.sv
module pll_run_ctrl
    import pllc_pkg::*;
#(
    parameter int SETTLE_CYC = 200,
    parameter int STOP_CYC   = 48,
    parameter int ADDR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              wr_unlock,
    input  logic              pll_is_sysclk,
    output logic [7:0]        bus_rdata,
    output logic              pll_run_en,
    output logic              pll_stable
);
    localparam int MAX_CYC = (SETTLE_CYC > STOP_CYC) ? SETTLE_CYC : STOP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int AGE_W   = CNT_W + 1;

    phase_e phase;
    logic   go_run, go_stop, bad_req;
    logic   stop_bit, err_flag, stable;
    logic   unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:1];

    pllc_gate #(.ADDR_W(ADDR_W)) u_gate (
        .bus_we        (bus_we),
        .wr_unlock     (wr_unlock),
        .bus_addr      (bus_addr),
        .want_stop     (bus_wdata[0]),
        .pll_is_sysclk (pll_is_sysclk),
        .phase         (phase),
        .go_run        (go_run),
        .go_stop       (go_stop),
        .bad_req       (bad_req)
    );

    pllc_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .STOP_CYC   (STOP_CYC),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_run  (go_run),
        .go_stop (go_stop),
        .phase   (phase),
        .stable  (stable)
    );

    pllc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_run    (go_run),
        .go_stop   (go_stop),
        .bad_req   (bad_req),
        .stable_in (stable),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .stop_bit  (stop_bit),
        .err_flag  (err_flag)
    );

    assign pll_run_en = ~stop_bit;
    assign pll_stable = stable;

    // Cycles since the run enable last changed, used only by the checks below.
    localparam logic [AGE_W-1:0] SETTLE_T = AGE_W'(SETTLE_CYC);
    localparam logic [AGE_W-1:0] STOP_T   = AGE_W'(STOP_CYC);
    logic             run_prev_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_prev_q <= 1'b0;
            age_q      <= '0;
        end else begin
            run_prev_q <= pll_run_en;
            if (pll_run_en != run_prev_q) age_q <= AGE_W'(1);
            else if (age_q != '1)         age_q <= age_q + 1'b1;
        end
    end

    assert_ctrl_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pll_run_en == (phase == PH_RAMP || phase == PH_LOCK));

    assert_settle_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_stable) |-> (age_q == SETTLE_T));

    assert_stop_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_stable) |-> (age_q == STOP_T));

    assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !wr_unlock) |=> ($stable(pll_run_en) && $stable(err_flag)));

    assert_sysclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && wr_unlock && bus_addr == '0 && bus_wdata[0] && pll_is_sysclk && pll_run_en)
        |=> pll_run_en);
endmodule

// File: tb/pll_run_ctrl_test.sv
module pll_run_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int T_SET  = 7;
    localparam int T_STP  = 3;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              wr_unlock = 1'b0;
    logic              pll_is_sysclk = 1'b0;
    logic [7:0]        bus_rdata;
    logic              pll_run_en;
    logic              pll_stable;

    int checks = 0;
    int errors = 0;
    int m_stop, m_err, m_stable, m_wait, p_stop, p_stable;
    bit cmp_en = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pll_run_ctrl #(.SETTLE_CYC(T_SET), .STOP_CYC(T_STP), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .wr_unlock(wr_unlock), .pll_is_sysclk(pll_is_sysclk),
        .bus_rdata(bus_rdata), .pll_run_en(pll_run_en), .pll_stable(pll_stable)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: stop bit, error bit, stable flag and a wait count.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop = 1; m_err = 0; m_stable = 0; m_wait = 0;
        end else begin
            p_stop   = m_stop;
            p_stable = m_stable;
            if (p_stop == p_stable) begin
                m_wait--;
                if (m_wait == 0) m_stable = 1 - m_stable;
            end
            if (bus_we && wr_unlock && bus_addr == 0) begin
                if (bus_wdata[0] == 1'b0 && p_stop == 1) begin
                    if (p_stable == 1) m_err = 1;
                    else begin m_stop = 0; m_wait = T_SET; end
                end else if (bus_wdata[0] == 1'b1 && p_stop == 0) begin
                    if (p_stable == 1 && !pll_is_sysclk) begin m_stop = 1; m_wait = T_STP; end
                    else m_err = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && cmp_en) begin
            check("R1 run_en vs model", int'(pll_run_en), 1 - m_stop);
            check("R5/R6 stable vs model", int'(pll_stable), m_stable);
            if (bus_addr == 0)      check("R3 rdata@0 vs model", int'(bus_rdata), m_stop);
            else if (bus_addr == 1) check("R11 rdata@1 vs model", int'(bus_rdata), m_err*2 + m_stable);
            else                    check("R3 rdata@other", int'(bus_rdata), 0);
        end
    end

    task automatic wr(input int a, input int d, input bit u);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = 8'(d);
        bus_we    = 1'b1;
        wr_unlock = u;
        @(negedge clk);
        bus_we    = 1'b0;
        wr_unlock = 1'b0;
    endtask

    task automatic peek(input int a, output int v);
        bus_addr = ADDR_W'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_flag(input bit lvl, output int n);
        n = 0;
        while (pll_stable != lvl && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R2 reset state
        peek(0, v); check("R2 reset rdata@0", v, 1);
        peek(1, v); check("R2 reset rdata@1", v, 0);
        check("R2 reset run_en", int'(pll_run_en), 0);
        check("R2 reset stable", int'(pll_stable), 0);

        // R4 locked write
        wr(0, 8'hFE, 1'b0);
        check("R4 locked write run_en", int'(pll_run_en), 0);
        peek(0, v); check("R4 locked write rdata@0", v, 1);

        // R10 writes to status and same-value writes
        wr(1, 8'hFF, 1'b1);
        peek(1, v); check("R10 status write ignored", v, 0);
        wr(0, 8'hFF, 1'b1);
        peek(0, v); check("R3 reserved bits read 0", v, 1);
        peek(1, v); check("R10 same value no error", v, 0);
        peek(2, v); check("R3 offset 2 reads 0", v, 0);

        // R5 start and settle time
        wr(0, 8'h00, 1'b1);
        check("R5 run_en after start", int'(pll_run_en), 1);
        wait_flag(1'b1, n);
        check("R5 settle cycles", n, T_SET);
        wr(0, 8'hA0, 1'b1);
        peek(1, v); check("R10 repeated start no error", v, 1);

        // R7 stop while PLL drives system clock
        pll_is_sysclk = 1'b1;
        wr(0, 8'h01, 1'b1);
        check("R7 run_en kept", int'(pll_run_en), 1);
        peek(1, v); check("R7 error set", v, 3);
        pll_is_sysclk = 1'b0;

        // R6 stop and wind-down time
        wr(0, 8'h01, 1'b1);
        check("R6 run_en after stop", int'(pll_run_en), 0);
        wait_flag(1'b0, n);
        check("R6 stop cycles", n, T_STP);
        wr(1, 8'h00, 1'b1);
        repeat (5) @(negedge clk);
        peek(1, v); check("R11 error sticky", v, 2);

        // R8 stop while settling
        do_reset();
        wr(0, 8'h00, 1'b1);
        wr(0, 8'h01, 1'b1);
        check("R8 run_en kept while settling", int'(pll_run_en), 1);
        peek(1, v); check("R8 error set", v, 2);

        // R9 restart while winding down
        do_reset();
        wr(0, 8'h00, 1'b1);
        wait_flag(1'b1, n);
        wr(0, 8'h01, 1'b1);
        wr(0, 8'h00, 1'b1);
        check("R9 run_en stays low", int'(pll_run_en), 0);
        peek(1, v); check("R9 error set", v, 3);
        wait_flag(1'b0, n);
        peek(0, v); check("R9 control still stopped", v, 1);

        // Random traffic against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_addr  = ADDR_W'($urandom % 4);
            bus_wdata = 8'($urandom);
            bus_we    = ($urandom % 3 == 0);
            wr_unlock = ($urandom % 4 != 0);
            if ($urandom % 10 == 0) pll_is_sysclk = ~pll_is_sysclk;
            if (i % 1000 == 999) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule